// File: doc/BRIEF.md
# Masked General Purpose I/O Port

This block is a 32-pin general purpose I/O port that software drives through a simple register bus. Every pin has its own direction bit. Software can change that bit at any time, so a pin can switch between input and output without touching its neighbours. The output register can be written whole in one bus write. Dedicated write-one-to-set and write-one-to-clear registers change any group of outputs without a read-modify-write.

A mask register protects selected bits. Writes to the output, set and clear registers leave those bits unchanged, and the pin register returns them as zero. A driver can therefore own a field of the port and update it alone. Every register takes byte, half-word or word accesses through per-byte lane enables. Pin inputs pass through a two-flop synchroniser before software can see them.

Register word addresses on `bus_addr` are:

| Address | Register |
|---------|----------|
| 0 | direction |
| 1 | output value |
| 2 | set |
| 3 | clear |
| 4 | mask |
| 5 | pin state |

Address 6 and address 7 are unused.

Top module: `gpio_port`

## Requirements
- R1: While reset is held, and after it is released, the direction, output and mask registers hold zero. `pin_oe` and `pin_out` are all zero, so every pin is an input.
- R2: `pin_oe` equals the direction register and `pin_out` equals the output register. A bus write to either register shows on these pins after the clock edge that accepts it.
- R3: A write to the output register (address 1) replaces every bit that is enabled and unmasked with the written value. No other bit changes. A cycle without a bus write changes no register.
- R4: A write to the set register (address 2) drives high each enabled, unmasked bit that is written as one. Bits written as zero keep their value.
- R5: A write to the clear register (address 3) drives low each enabled, unmasked bit that is written as one. Bits written as zero keep their value.
- R6: A mask bit of one blocks changes to that output bit through addresses 1, 2 and 3. Writes to the direction register (address 0) and the mask register (address 4) are not affected by the mask.
- R7: `bus_be[i]` enables data bits 8*i+7 down to 8*i for a write to any register. Bytes whose enable is low keep their value.
- R8: A read of address 1 returns the output register, whatever the pin directions, the pin inputs or the mask.
- R9: A read of address 5 returns the synchronised pin inputs, with masked bits forced to zero. A change on `pin_in` set up before clock edge k becomes readable after clock edge k+1.
- R10: Reads have no side effects. The read data is zero when `bus_en` is low, during a write, and for addresses 2, 3, 6 and 7. Reads of address 0 and address 4 return the direction and mask registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output values for the pins |
| pin_oe | output | 32 | Output enables, 1 = pin is an output |

## Verification
The block's state lives in the direction, output and mask registers. The first two show on `pin_oe` and `pin_out` on the edge after each write, so a wrong bit caused by a lane, mask or set/clear error shows at the ports one cycle after the write that caused it. A wrong mask bit shows at the ports only through later accesses: a read of address 4, a masked bit that reads as nonzero on address 5, or an output that changes when it should stay fixed. The synchroniser depth is visible as the number of edges between a change on `pin_in` and its first appearance on address 5.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [2:0]     bus_addr,
  input  logic [W/8-1:0] bus_be,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  input  logic [W-1:0]   pin_in,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe
);
  localparam int NB = W / 8;
  localparam logic [2:0] A_DIR  = 3'd0;
  localparam logic [2:0] A_OUT  = 3'd1;
  localparam logic [2:0] A_SET  = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_MASK = 3'd4;
  localparam logic [2:0] A_PIN  = 3'd5;

  logic [W-1:0] lane;
  logic [W-1:0] dir_q, out_q, mask_q, sync1_q, sync2_q;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane[b*8 +: 8] = {8{bus_be[b]}};
  end

  wire          wr    = bus_en & bus_we;
  wire [W-1:0]  wmask = lane & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      mask_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (wr) begin
        case (bus_addr)
          A_DIR:   dir_q  <= (dir_q & ~lane) | (bus_wdata & lane);
          A_OUT:   out_q  <= (out_q & ~wmask) | (bus_wdata & wmask);
          A_SET:   out_q  <= out_q | (bus_wdata & wmask);
          A_CLR:   out_q  <= out_q & ~(bus_wdata & wmask);
          A_MASK:  mask_q <= (mask_q & ~lane) | (bus_wdata & lane);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        A_DIR:   bus_rdata = dir_q;
        A_OUT:   bus_rdata = out_q;
        A_MASK:  bus_rdata = mask_q;
        A_PIN:   bus_rdata = sync2_q & ~mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_en,
  input logic           bus_we,
  input logic [2:0]     bus_addr,
  input logic [W/8-1:0] bus_be,
  input logic [W-1:0]   bus_wdata,
  input logic [W-1:0]   bus_rdata,
  input logic [W-1:0]   pin_out,
  input logic [W-1:0]   pin_oe,
  input logic [W-1:0]   mask
);
  logic [W-1:0] lane;
  for (genvar b = 0; b < W/8; b++) begin : g_l
    assign lane[b*8 +: 8] = {8{bus_be[b]}};
  end
  wire          wr   = bus_en && bus_we;
  wire          outw = wr && (bus_addr == 3'd1 || bus_addr == 3'd2 || bus_addr == 3'd3);
  wire [W-1:0]  hit  = bus_wdata & lane & ~mask;

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(pin_out) && $stable(pin_oe));                                 // R3
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 3'd2) |=> ((pin_out & $past(hit)) == $past(hit)));         // R4
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 3'd3) |=> ((pin_out & $past(hit)) == '0));                 // R5
  AST_MASK_GUARDS: assert property (@(posedge clk) disable iff (!rst_n)
    outw |=> (((pin_out ^ $past(pin_out)) & $past(mask)) == '0));                 // R6
  AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 3'd0) |=> (((pin_oe ^ $past(pin_oe)) & ~$past(lane)) == '0)); // R7
  AST_PIN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 3'd5) |-> ((bus_rdata & mask) == '0));      // R9
  AST_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en || bus_we || bus_addr == 3'd2 || bus_addr == 3'd3 || bus_addr[2:1] == 2'b11)
      |-> bus_rdata == '0);                                                        // R10
endmodule

bind gpio_port gpio_port_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .mask(mask_q)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [2:0]  bus_addr = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0, pin_in = 0;
  logic [31:0] bus_rdata, pin_out, pin_oe;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_dir = 0, m_out = 0, m_mask = 0;

  always #2 clk = ~clk;

  gpio_port uut (.clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_be,
                 .bus_wdata, .bus_rdata, .pin_in, .pin_out, .pin_oe);

  function automatic logic [31:0] lanes(input logic [3:0] be);
    for (int i = 0; i < 4; i++) lanes[i*8 +: 8] = {8{be[i]}};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [31:0] en);
    return (old & ~en) | (d & en);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] en;
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    en = lanes(be) & ~m_mask;
    case (a)
      3'd0: m_dir  = merge(m_dir, d, lanes(be));
      3'd1: m_out  = merge(m_out, d, en);
      3'd2: m_out  = m_out | (d & en);
      3'd3: m_out  = m_out & ~(d & en);
      3'd4: m_mask = merge(m_mask, d, lanes(be));
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic pins(input string req);
    check(req, pin_out, m_out);
    check(req, pin_oe, m_dir);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pin_oe, 0);
    check("R1 out in reset", pin_out, 0);
    rst_n = 1;
    rd(3'd0, d); check("R1 dir", d, 0);
    rd(3'd1, d); check("R1 out", d, 0);
    rd(3'd4, d); check("R1 mask", d, 0);

    wr(3'd1, 4'hF, 32'hA5A5_0FF0); pins("R2 full-word out write");
    check("R3 full write", pin_out, 32'hA5A5_0FF0);
    wr(3'd0, 4'h3, 32'hFFFF_FFFF); check("R7 dir half-word", pin_oe, 32'h0000_FFFF);
    wr(3'd2, 4'hF, 32'h0000_000F); check("R4 set low nibble", pin_out, 32'hA5A5_0FFF);
    wr(3'd3, 4'hF, 32'h8000_0001); check("R5 clear two bits", pin_out, 32'h25A5_0FFE);
    wr(3'd4, 4'hF, 32'h0000_FF00);
    wr(3'd1, 4'hF, 32'hFFFF_FFFF); check("R6 masked out write", pin_out, 32'hFFFF_0FFF);
    wr(3'd3, 4'hF, 32'hFFFF_FFFF); check("R6 masked clear", pin_out, 32'h0000_0F00);
    wr(3'd0, 4'h2, 32'h0000_0000); check("R6 dir ignores mask", pin_oe, 32'h0000_00FF);
    pin_in = 32'hDEAD_BEEF; pins("R8 before read");
    rd(3'd1, d); check("R8 out readback", d, 32'h0000_0F00);
    rd(3'd5, d); check("R9 masked pins", d, 32'hDEAD_BEEF & ~32'h0000_FF00);
    rd(3'd2, d); check("R10 set reads zero", d, 0);
    rd(3'd7, d); check("R10 unused reads zero", d, 0);
    pins("R10 read no side effect");

    @(negedge clk); pin_in = 32'h1234_5678;
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 3'd5;
    #1 check("R9 one edge old", bus_rdata, 32'hDEAD_BEEF & ~32'h0000_FF00);
    @(negedge clk); #1 check("R9 two edges new", bus_rdata, 32'h1234_5678 & ~32'h0000_FF00);
    bus_en = 0;

    for (int i = 0; i < 400; i++) begin
      logic [2:0] a; logic [3:0] be; logic [31:0] v;
      a = 3'($urandom_range(0, 7)); be = 4'($urandom); v = $urandom;
      wr(a, be, v);
      pins("R2 R3 R4 R5 R6 R7 random");
      if (i % 8 == 0) begin
        pin_in = $urandom;
        repeat (2) @(negedge clk);
        rd(3'd5, d); check("R9 random pins", d, pin_in & ~m_mask);
        rd(3'd4, d); check("R10 mask read", d, m_mask);
        rd(3'd0, d); check("R10 dir read", d, m_dir);
        rd(3'd1, d); check("R8 random out read", d, m_out);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule